// File: doc/BRIEF.md
# Rotating Multi-Buffer Packet FIFO with Automatic Commit

This block sits between a byte-wide sampling engine and a packet reader. The producer pushes one byte per cycle into whichever buffer is being filled. Once that buffer holds the programmed packet length, it is handed to the consumer with no further action. Filling then moves on to the next buffer of a fixed ring.

The consumer sees whether a packet is waiting and how long it is. It walks through the bytes with a read strobe. It gives the whole buffer back with a single release strobe, and the buffer may be refilled on the very next cycle.

When every buffer in the ring is committed and unread, a full flag is raised. The sampling engine uses this flag as its stall condition. A write that arrives while the flag is set is discarded and leaves a sticky overflow mark. A flush command returns the whole block to its empty state.

Top module: `auto_commit_pkt_fifo`

## Requirements
- R1: After reset or a one-cycle `flush` pulse, the outputs read as follows from the next cycle: `full`=0, `pkt_avail`=0, `overflow`=0 and `pkt_len`=0.
- R2: The effective packet length L is `commit_len` when it lies in 1..BUF_DEPTH, and BUF_DEPTH when it is 0 or larger than BUF_DEPTH. The cycle after the L-th accepted write into a buffer, that buffer is committed: `pkt_avail`=1 and, if it is the oldest, `pkt_len`=L. Before that write it is not visible.
- R3: A write with `wr_en`=1 while `full`=1 is discarded: its byte never appears at `rd_data`. It sets `overflow`, which stays 1 until reset or flush.
- R4: `full` is 1 exactly while all NUM_BUF buffers hold committed, unreleased packets.
- R5: Packets reach the consumer in the order they were committed, with the buffers used in round-robin order.
- R6: For the oldest packet, `rd_data` first shows byte 0. Each `rd_en` moves it to the next byte. At the last byte (index L-1), `rd_en` leaves `rd_data` on that byte.
- R7: `rd_release` while `pkt_avail`=1 drops the oldest packet. If `full` was 1, it reads 0 on the next cycle and a write in that cycle is accepted. `rd_release` while `pkt_avail`=0 has no effect.
- R8: A flush discards committed packets and the partly filled buffer. The next packet holds only bytes written after the flush.
- R9: A commit and a release in the same cycle leave the number of waiting packets unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear of all buffers and flags |
| commit_len | input | LEN_W (10) | Programmed packet length; 0 or above BUF_DEPTH means BUF_DEPTH |
| wr_data | input | DATA_W (8) | Producer byte |
| wr_en | input | 1 | Producer write strobe |
| full | output | 1 | No buffer free for the producer |
| overflow | output | 1 | Sticky: a write was dropped while full |
| pkt_avail | output | 1 | At least one committed packet waiting |
| pkt_len | output | LEN_W (10) | Length of the oldest waiting packet, 0 when none |
| rd_data | output | DATA_W (8) | Byte at the read position of the oldest packet |
| rd_en | input | 1 | Advance the read position |
| rd_release | input | 1 | Return the oldest buffer to the producer |

## Verification
On every cycle the assertions check these properties:
- The distance between the fill slot and the drain slot around the ring matches the waiting-packet count.
- The count never exceeds the ring size.
- The read position stays inside the oldest packet.
- A release rewinds the read position and clears `full`.
- A dropped write sets `overflow`, and `overflow` stays set.

The bench's scenarios show what depends on data and history. These cover the following:
- Bytes come back intact and in commit order.
- The length clamp for 0 and oversized settings.
- A dropped byte never resurfaces.
- A simultaneous commit and release keeps the count.
- A flush discards a half-filled buffer.

// File: rtl/acpf_pkg.sv
package acpf_pkg;

  // Packet length actually used for a requested value.
  function automatic int unsigned acpf_eff_len(input int unsigned req, input int unsigned depth);
    if (req == 0 || req > depth) return depth;
    return req;
  endfunction

  // Next slot around a ring of n buffers.
  function automatic int unsigned acpf_next(input int unsigned idx, input int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  // Slots from tail forward to head around a ring of n buffers.
  function automatic int unsigned acpf_dist(input int unsigned head, input int unsigned tail,
                                            input int unsigned n);
    return (head >= tail) ? head - tail : head + n - tail;
  endfunction

endpackage

// File: rtl/acpf_fill.sv
module acpf_fill import acpf_pkg::*; #(
  parameter int unsigned NUM_BUF   = 4,
  parameter int unsigned BUF_DEPTH = 512,
  parameter int unsigned IDX_W     = 2,
  parameter int unsigned PTR_W     = 9,
  parameter int unsigned LEN_W     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic             full,
  input  logic [LEN_W-1:0] len_req,
  output logic [IDX_W-1:0] fill_idx,
  output logic [PTR_W-1:0] fill_ptr,
  output logic             wr_accept,
  output logic             commit_ev,
  output logic [LEN_W-1:0] commit_cnt,
  output logic             overflow
);
  logic [LEN_W-1:0] len_lim;
  logic [LEN_W-1:0] cnt_next;

  assign len_lim    = LEN_W'(acpf_eff_len(32'(len_req), BUF_DEPTH));
  assign cnt_next   = LEN_W'(fill_ptr) + LEN_W'(1);
  assign wr_accept  = wr_en && !full;
  assign commit_ev  = wr_accept && (cnt_next >= len_lim);
  assign commit_cnt = cnt_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_idx <= '0;
      fill_ptr <= '0;
      overflow <= 1'b0;
    end else if (flush) begin
      fill_idx <= '0;
      fill_ptr <= '0;
      overflow <= 1'b0;
    end else begin
      if (wr_en && full) overflow <= 1'b1;
      if (commit_ev) begin
        fill_ptr <= '0;
        fill_idx <= IDX_W'(acpf_next(32'(fill_idx), NUM_BUF));
      end else if (wr_accept) begin
        fill_ptr <= fill_ptr + PTR_W'(1);
      end
    end
  end

  // R3: a write refused for lack of space is remembered
  p_drop_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !flush) |=> overflow);

  // R3: the overflow mark only clears through flush
  p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !flush) |=> overflow);

endmodule

// File: rtl/acpf_drain.sv
module acpf_drain import acpf_pkg::*; #(
  parameter int unsigned NUM_BUF = 4,
  parameter int unsigned IDX_W   = 2,
  parameter int unsigned PTR_W   = 9,
  parameter int unsigned LEN_W   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             rd_en,
  input  logic             rd_release,
  input  logic             pkt_avail,
  input  logic [LEN_W-1:0] head_len,
  output logic [IDX_W-1:0] rd_idx,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             release_ev
);
  logic step_ok;

  assign release_ev = rd_release && pkt_avail;
  assign step_ok    = rd_en && pkt_avail && ((LEN_W'(rd_ptr) + LEN_W'(1)) < head_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_idx <= '0;
      rd_ptr <= '0;
    end else if (flush) begin
      rd_idx <= '0;
      rd_ptr <= '0;
    end else if (release_ev) begin
      rd_idx <= IDX_W'(acpf_next(32'(rd_idx), NUM_BUF));
      rd_ptr <= '0;
    end else if (step_ok) begin
      rd_ptr <= rd_ptr + PTR_W'(1);
    end
  end

  // R6: the read position never leaves the oldest packet
  p_ptr_in_packet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_avail |-> (LEN_W'(rd_ptr) < head_len));

  // R7: a release starts the next packet at its first byte
  p_release_rewinds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    release_ev |=> (rd_ptr == '0));

endmodule

// File: rtl/acpf_occupancy.sv
module acpf_occupancy #(
  parameter int unsigned NUM_BUF = 4,
  parameter int unsigned CNT_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             commit_ev,
  input  logic             release_ev,
  output logic [CNT_W-1:0] occ_cnt,
  output logic             full,
  output logic             pkt_avail
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_cnt <= '0;
    end else if (flush) begin
      occ_cnt <= '0;
    end else begin
      case ({commit_ev, release_ev})
        2'b10:   occ_cnt <= occ_cnt + CNT_W'(1);
        2'b01:   occ_cnt <= occ_cnt - CNT_W'(1);
        default: occ_cnt <= occ_cnt;
      endcase
    end
  end

  assign full      = (occ_cnt == CNT_W'(NUM_BUF));
  assign pkt_avail = (occ_cnt != '0);

  // R4: never more waiting packets than buffers
  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    occ_cnt <= CNT_W'(NUM_BUF));

  // R7: releasing from a full ring frees a slot at once
  p_full_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && release_ev && !flush) |=> !full);

endmodule

// File: rtl/acpf_store.sv
module acpf_store #(
  parameter int unsigned NUM_BUF   = 4,
  parameter int unsigned BUF_DEPTH = 512,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned IDX_W     = 2,
  parameter int unsigned PTR_W     = 9,
  parameter int unsigned LEN_W     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [PTR_W-1:0]  wptr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              commit_ev,
  input  logic [LEN_W-1:0]  commit_cnt,
  input  logic [IDX_W-1:0]  ridx,
  input  logic [PTR_W-1:0]  rptr,
  output logic [DATA_W-1:0] rdata,
  output logic [LEN_W-1:0]  head_len
);
  logic [DATA_W-1:0] rd_word  [NUM_BUF];
  logic [LEN_W-1:0]  len_word [NUM_BUF];

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    logic [DATA_W-1:0] cells [BUF_DEPTH];
    logic [LEN_W-1:0]  len_q;

    always_ff @(posedge clk) begin
      if (we && widx == IDX_W'(b)) cells[wptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               len_q <= '0;
      else if (flush)                           len_q <= '0;
      else if (commit_ev && widx == IDX_W'(b))  len_q <= commit_cnt;
    end

    assign rd_word[b]  = cells[rptr];
    assign len_word[b] = len_q;
  end

  assign rdata    = rd_word[ridx];
  assign head_len = len_word[ridx];

endmodule

// File: rtl/auto_commit_pkt_fifo.sv
module auto_commit_pkt_fifo import acpf_pkg::*; #(
  parameter int unsigned NUM_BUF   = 4,
  parameter int unsigned BUF_DEPTH = 512,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned LEN_W     = $clog2(BUF_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [LEN_W-1:0]  commit_len,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en,
  output logic              full,
  output logic              overflow,
  output logic              pkt_avail,
  output logic [LEN_W-1:0]  pkt_len,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rd_en,
  input  logic              rd_release
);
  localparam int unsigned IDX_W = $clog2(NUM_BUF);
  localparam int unsigned PTR_W = $clog2(BUF_DEPTH);
  localparam int unsigned CNT_W = $clog2(NUM_BUF + 1);

  logic [IDX_W-1:0] fill_idx, rd_idx;
  logic [PTR_W-1:0] fill_ptr, rd_ptr;
  logic [LEN_W-1:0] commit_cnt, head_len;
  logic [CNT_W-1:0] occ_cnt;
  logic             wr_accept, commit_ev, release_ev;

  acpf_fill #(.NUM_BUF(NUM_BUF), .BUF_DEPTH(BUF_DEPTH), .IDX_W(IDX_W),
              .PTR_W(PTR_W), .LEN_W(LEN_W)) u_fill (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .full(full),
    .len_req(commit_len), .fill_idx(fill_idx), .fill_ptr(fill_ptr),
    .wr_accept(wr_accept), .commit_ev(commit_ev), .commit_cnt(commit_cnt),
    .overflow(overflow)
  );

  acpf_occupancy #(.NUM_BUF(NUM_BUF), .CNT_W(CNT_W)) u_occ (
    .clk(clk), .rst_n(rst_n), .flush(flush), .commit_ev(commit_ev),
    .release_ev(release_ev), .occ_cnt(occ_cnt), .full(full), .pkt_avail(pkt_avail)
  );

  acpf_drain #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W), .PTR_W(PTR_W), .LEN_W(LEN_W)) u_drain (
    .clk(clk), .rst_n(rst_n), .flush(flush), .rd_en(rd_en), .rd_release(rd_release),
    .pkt_avail(pkt_avail), .head_len(head_len), .rd_idx(rd_idx), .rd_ptr(rd_ptr),
    .release_ev(release_ev)
  );

  acpf_store #(.NUM_BUF(NUM_BUF), .BUF_DEPTH(BUF_DEPTH), .DATA_W(DATA_W),
               .IDX_W(IDX_W), .PTR_W(PTR_W), .LEN_W(LEN_W)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush), .we(wr_accept), .widx(fill_idx),
    .wptr(fill_ptr), .wdata(wr_data), .commit_ev(commit_ev), .commit_cnt(commit_cnt),
    .ridx(rd_idx), .rptr(rd_ptr), .rdata(rd_data), .head_len(head_len)
  );

  assign pkt_len = pkt_avail ? head_len : '0;

  // R5: fill slot leads drain slot by exactly the waiting-packet count
  p_ring_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acpf_dist(32'(fill_idx), 32'(rd_idx), NUM_BUF) == (32'(occ_cnt) % NUM_BUF));

endmodule

// File: tb/auto_commit_pkt_fifo_test.sv
module auto_commit_pkt_fifo_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flush = 1'b0;
  logic [9:0] commit_len = 10'd4;
  logic [7:0] wr_data = 8'h00;
  logic       wr_en = 1'b0;
  logic       full, overflow, pkt_avail;
  logic [9:0] pkt_len;
  logic [7:0] rd_data;
  logic       rd_en = 1'b0;
  logic       rd_release = 1'b0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  auto_commit_pkt_fifo uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .commit_len(commit_len),
    .wr_data(wr_data), .wr_en(wr_en), .full(full), .overflow(overflow),
    .pkt_avail(pkt_avail), .pkt_len(pkt_len), .rd_data(rd_data),
    .rd_en(rd_en), .rd_release(rd_release)
  );

  typedef struct packed {
    logic [9:0] clen;
    logic [7:0] base;
    logic [9:0] exp_len;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{10'd4,   8'h10, 10'd4},
    '{10'd1,   8'hA0, 10'd1},
    '{10'd7,   8'h33, 10'd7},
    '{10'd0,   8'h00, 10'd512},
    '{10'd600, 8'h80, 10'd512},
    '{10'd2,   8'hF0, 10'd2}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    wr_data = b;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rel();
    rd_release = 1'b1;
    @(negedge clk);
    rd_release = 1'b0;
  endtask

  task automatic read_pkt(input int len, input logic [7:0] base, input string tag);
    for (int i = 0; i < len; i++) begin
      chk(rd_data == 8'(base + i), tag, rd_data, 8'(base + i));
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
    end
    chk(rd_data == 8'(base + len - 1), "R6 hold at last byte", rd_data, 8'(base + len - 1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(full == 1'b0, "R1 reset full", full, 0);
    chk(pkt_avail == 1'b0, "R1 reset pkt_avail", pkt_avail, 0);
    chk(overflow == 1'b0, "R1 reset overflow", overflow, 0);
    chk(pkt_len == 10'd0, "R1 reset pkt_len", pkt_len, 0);

    // R2 / R6 / R7 table walk
    foreach (VECS[k]) begin
      commit_len = VECS[k].clen;
      for (int i = 0; i < int'(VECS[k].exp_len) - 1; i++) wr(8'(VECS[k].base + i));
      chk(pkt_avail == 1'b0, "R2 not visible before last byte", pkt_avail, 0);
      wr(8'(VECS[k].base + VECS[k].exp_len - 1));
      chk(pkt_avail == 1'b1, "R2 committed at length", pkt_avail, 1);
      chk(pkt_len == VECS[k].exp_len, "R2 committed length", pkt_len, VECS[k].exp_len);
      read_pkt(int'(VECS[k].exp_len), VECS[k].base, "R6 byte order");
      rel();
      chk(pkt_avail == 1'b0, "R7 release empties", pkt_avail, 0);
    end

    // R4 / R3: fill the whole ring
    commit_len = 10'd2;
    for (int p = 0; p < 4; p++) begin
      wr(8'(p * 16));
      wr(8'(p * 16 + 1));
      if (p < 3) chk(full == 1'b0, "R4 not full before last buffer", full, 0);
    end
    chk(full == 1'b1, "R4 full with all buffers committed", full, 1);
    wr(8'hEE);
    chk(overflow == 1'b1, "R3 overflow set by dropped write", overflow, 1);
    chk(full == 1'b1, "R4 still full after dropped write", full, 1);
    read_pkt(2, 8'h00, "R5 first packet");
    rel();
    chk(full == 1'b0, "R7 full clears after release", full, 0);
    wr(8'h40);
    wr(8'h41);
    chk(full == 1'b1, "R7 freed buffer refilled next cycle", full, 1);
    chk(overflow == 1'b1, "R3 overflow sticky", overflow, 1);
    for (int p = 1; p < 5; p++) begin
      chk(pkt_len == 10'd2, "R5 packet length", pkt_len, 2);
      read_pkt(2, 8'(p * 16), "R5 commit order");
      rel();
    end
    chk(pkt_avail == 1'b0, "R3 dropped byte never delivered", pkt_avail, 0);

    // R7: release with nothing waiting
    rel();
    wr(8'h55);
    wr(8'h56);
    chk(pkt_avail == 1'b1, "R7 idle release ignored avail", pkt_avail, 1);
    chk(rd_data == 8'h55, "R7 idle release ignored data", rd_data, 8'h55);

    // R9: commit and release together
    wr(8'h60);
    wr_data = 8'h61;
    wr_en = 1'b1;
    rd_release = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    rd_release = 1'b0;
    chk(pkt_avail == 1'b1, "R9 count kept avail", pkt_avail, 1);
    chk(rd_data == 8'h60, "R9 next packet at head", rd_data, 8'h60);
    chk(pkt_len == 10'd2, "R9 next packet length", pkt_len, 2);
    rel();
    chk(pkt_avail == 1'b0, "R9 single packet was waiting", pkt_avail, 0);

    // R1 / R8: flush with committed and partial data
    wr(8'h70);
    wr(8'h71);
    wr(8'h72);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    chk(pkt_avail == 1'b0, "R1 flush pkt_avail", pkt_avail, 0);
    chk(full == 1'b0, "R1 flush full", full, 0);
    chk(overflow == 1'b0, "R1 flush overflow", overflow, 0);
    chk(pkt_len == 10'd0, "R1 flush pkt_len", pkt_len, 0);
    wr(8'h90);
    chk(pkt_avail == 1'b0, "R8 partial byte discarded", pkt_avail, 0);
    wr(8'h91);
    chk(pkt_avail == 1'b1, "R8 fresh packet", pkt_avail, 1);
    read_pkt(2, 8'h90, "R8 fresh packet data");

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule